// File: doc/BRIEF.md
# GPIO Controller with Edge Detection

This block is a 28-pin general-purpose I/O peripheral on a simple word-addressed register bus. Software reads the synchronized pin levels and chooses a direction for each pin. It drives the output latch through two write-only ports, one that sets bits and one that clears them, so that no read-modify-write is needed. Each pin can be armed to catch rising edges, falling edges, or both. A caught edge sets a sticky event bit, which software clears by writing a 1 to it.

The event bits drive the interrupt outputs. Pins 0 to 10 each have their own line. Pins 11 to 27 share one line. Each line is a level: it stays high while any event bit it covers is set. A 32-bit alternate-function word is stored and read back, and it has no effect inside the block.

Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with its sample from one cycle earlier. The bus address is a 3-bit word index. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational on `bus_addr`.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, `pin_oe`, `pin_out` and all interrupt outputs are 0. Word indices 1 to 7 read as 0, and with the pins held low word 0 also reads 0.
- R2: Word 1 is the direction register and reads back as written. Bit i = 1 drives `pin_oe[i]` high, which makes pin i an output.
- R3: A write to word 2 sets every `pin_out` bit whose data bit is 1 and leaves bits written as 0 unchanged. Word 2 reads as 0.
- R4: A write to word 3 clears every `pin_out` bit whose data bit is 1 and leaves bits written as 0 unchanged. Word 3 reads as 0.
- R5: Word 0 returns the pin levels, bit i for pin i. A change on `pin_in` appears there after the second rising clock edge. Writes to word 0 are ignored.
- R6: With bit i of word 4 (rising enable) set, a low-to-high change on pin i sets event bit i. The bit is visible after the third rising clock edge following the change.
- R7: With bit i of word 5 (falling enable) set, a high-to-low change on pin i sets event bit i, with the same latency as R6.
- R8: A pin with both enables set records either edge. A pin with neither enable set, or with only the opposite enable set, records nothing.
- R9: Word 6 holds the event bits. They stay set until a 1 is written to them. Bits written as 0 are untouched, and writing all 1s clears every event.
- R10: If a new edge and a write-1-to-clear reach the same event bit in the same cycle, the bit stays set.
- R11: `irq_pin[i]` equals event bit i for pins 0 to 10. `irq_shared` is the OR of event bits 11 to 27.
- R12: Word 7 stores all 32 written bits, reads them back, and does not affect `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 28 | Pad input levels |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable (1 = output) |
| irq_pin | output | 11 | Interrupt lines for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt line for pins 11 to 27 |

## Verification
The main risk in this block is a corrupted event bit. A bit that fails to set, or one that clears on its own, shows on `irq_pin` or `irq_shared` and on word 6 in the cycle after the third rising edge that follows the pin change. A bit that sets with no enabled edge shows at the same place, at the same time. The bench samples exactly at that edge and one edge earlier, so a shortened or lengthened synchronizer also shows at the ports. Latch errors appear on `pin_out` in the cycle after the write. A lost edge during a clear shows as word 6 reading 0 right after the colliding write.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_EVT   = 3'd6,
    REG_ALT   = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] status_q
);
  function automatic logic [W-1:0] find_edges(input logic [W-1:0] c, p, r, f);
    return (c & ~p & r) | (~c & p & f);
  endfunction

  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] old, clr, hit);
    return (old & ~clr) | hit;
  endfunction

  assign edge_hit = find_edges(cur, prev, rise_en, fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= sticky_next(status_q, clr_mask, edge_hit);
  end

  // R6 R7 R10: every detected edge lands in its status bit, clear or not
  assert_edge_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R9: set bits not named by a clear stay set
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & ~clr_mask)) |=>
      ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

  // R8: no bit rises without an enabled edge
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_hit)) == '0));
endmodule

// File: rtl/gpio_irq_fold.sv
module gpio_irq_fold #(
  parameter int W       = 28,
  parameter int NDIRECT = 11
) (
  input  logic [W-1:0]       status,
  output logic [NDIRECT-1:0] irq_pin,
  output logic               irq_shared
);
  localparam int NSHARED = W - NDIRECT;

  for (genvar i = 0; i < NDIRECT; i++) begin : g_direct
    assign irq_pin[i] = status[i];
  end

  if (NSHARED > 0) begin : g_shared
    assign irq_shared = |status[W-1:NDIRECT];
  end else begin : g_noshared
    assign irq_shared = 1'b0;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPIN    = 28,
  parameter int NDIRECT = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NPIN-1:0]    pin_in,
  output logic [NPIN-1:0]    pin_out,
  output logic [NPIN-1:0]    pin_oe,
  output logic [NDIRECT-1:0] irq_pin,
  output logic               irq_shared
);
  localparam int PAD = BUS_W - NPIN;

  function automatic logic [BUS_W-1:0] widen(input logic [NPIN-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  function automatic logic [NPIN-1:0] latch_next(input logic [NPIN-1:0] old, s, c);
    return (old | s) & ~c;
  endfunction

  logic [NPIN-1:0]  dir_q, out_q, rise_q, fall_q;
  logic [BUS_W-1:0] alt_q;
  logic [NPIN-1:0]  pin_sync, pin_prev, edge_hit, evt_q;
  logic [NPIN-1:0]  wd_pins, set_mask, clr_mask, evt_clr;
  logic             wr_en;
  gpio_reg_e        reg_sel;

  assign reg_sel  = gpio_reg_e'(bus_addr);
  assign wr_en    = bus_sel && bus_wr;
  assign wd_pins  = bus_wdata[NPIN-1:0];
  assign set_mask = (wr_en && reg_sel == REG_SET) ? wd_pins : '0;
  assign clr_mask = (wr_en && reg_sel == REG_CLR) ? wd_pins : '0;
  assign evt_clr  = (wr_en && reg_sel == REG_EVT) ? wd_pins : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else begin
      out_q <= latch_next(out_q, set_mask, clr_mask);
      if (wr_en) begin
        case (reg_sel)
          REG_DIR:  dir_q  <= wd_pins;
          REG_RISE: rise_q <= wd_pins;
          REG_FALL: fall_q <= wd_pins;
          REG_ALT:  alt_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
    .sync_q(pin_sync), .prev_q(pin_prev)
  );

  gpio_edge_status #(.W(NPIN)) u_status (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .prev(pin_prev),
    .rise_en(rise_q), .fall_en(fall_q), .clr_mask(evt_clr),
    .edge_hit(edge_hit), .status_q(evt_q)
  );

  gpio_irq_fold #(.W(NPIN), .NDIRECT(NDIRECT)) u_irq (
    .status(evt_q), .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  always_comb begin
    case (reg_sel)
      REG_LEVEL: bus_rdata = widen(pin_sync);
      REG_DIR:   bus_rdata = widen(dir_q);
      REG_RISE:  bus_rdata = widen(rise_q);
      REG_FALL:  bus_rdata = widen(fall_q);
      REG_EVT:   bus_rdata = widen(evt_q);
      REG_ALT:   bus_rdata = alt_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R3: after a set-port write the named bits are high
  assert_set_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_SET) |=> ((pin_out & $past(wd_pins)) == $past(wd_pins)));

  // R4: after a clear-port write the named bits are low
  assert_clr_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_CLR) |=> ((pin_out & $past(wd_pins)) == '0));

  // R12: a write to the alternate-function word leaves the pins alone
  assert_alt_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == REG_ALT) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R1: leaving reset, the pins are inputs and the latch is low
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && evt_q == '0));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [27:0] pin_in = '0;
  logic [27:0] pin_out, pin_oe;
  logic [10:0] irq_pin;
  logic        irq_shared;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  // Word indices: 0 level, 1 dir, 2 set, 3 clear, 4 rise, 5 fall, 6 event, 7 alt
  // Entry: {write, addr, data, expected, requirement number}
  localparam int NVEC = 10;
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 32'h0000_00FF, 32'h0,          4'd2},  // R2 write dir
    {1'b0, 3'd1, 32'h0,          32'h0000_00FF, 4'd2},  // R2 read dir
    {1'b1, 3'd2, 32'h0F00_0F0F, 32'h0,          4'd3},  // R3 set
    {1'b0, 3'd2, 32'h0,          32'h0,          4'd3},  // R3 reads 0
    {1'b1, 3'd3, 32'h0000_0F00, 32'h0,          4'd4},  // R4 clear
    {1'b0, 3'd3, 32'h0,          32'h0,          4'd4},  // R4 reads 0
    {1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0,          4'd12}, // R12 write alt
    {1'b0, 3'd7, 32'h0,          32'hFFFF_FFFF, 4'd12}, // R12 read alt
    {1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0,          4'd5},  // R5 write ignored
    {1'b0, 3'd0, 32'h0,          32'h0,          4'd5}   // R5 level low
  };

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", {4'h0, pin_oe}, 32'h0);
    check("R1 pin_out", {4'h0, pin_out}, 32'h0);
    check("R1 irq", {20'h0, irq_shared, irq_pin}, 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 register reads 0", d, 32'h0);
    end

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][71]) wr(VEC[i][70:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][70:68], d);
        checks++;
        if (d !== VEC[i][35:4]) begin
          fails++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][3:0], i, d, VEC[i][35:4]);
        end
      end
    end
    check("R3 R4 pin_out latch", {4'h0, pin_out}, 32'h0F00_000F);
    check("R2 R12 pin_oe", {4'h0, pin_oe}, 32'h0000_00FF);

    // R5 level latency: two rising edges
    @(negedge clk); pin_in = 28'hABC_DEF1; bus_addr = 3'd0;
    @(negedge clk); check("R5 level after one edge", bus_rdata, 32'h0);
    @(negedge clk); check("R5 level after two edges", bus_rdata, 32'h0ABC_DEF1);
    pin_in = '0;
    repeat (4) @(negedge clk);
    wr(3'd6, 32'hFFFF_FFFF);

    // R6 rising enable on pins 0 and 12; pin 5 not enabled
    wr(3'd4, 32'h0000_1001);
    @(negedge clk); pin_in = 28'h000_1021; bus_addr = 3'd6;
    @(negedge clk); @(negedge clk);
    check("R6 no event after two edges", bus_rdata, 32'h0);
    @(negedge clk);
    check("R6 rising event", bus_rdata, 32'h0000_1001);
    check("R11 per-pin irq", {21'h0, irq_pin}, 32'h1);
    check("R11 shared irq", {31'h0, irq_shared}, 32'h1);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R9 clear all", d, 32'h0);
    check("R11 irq low after clear", {20'h0, irq_shared, irq_pin}, 32'h0);
    pin_in = '0;
    repeat (4) @(negedge clk);
    wr(3'd6, 32'hFFFF_FFFF);

    // R7 R8: pin 20 both edges, pin 1 falling only
    wr(3'd4, 32'h0010_0000);
    wr(3'd5, 32'h0010_0002);
    @(negedge clk); pin_in = 28'h010_0002;
    repeat (4) @(negedge clk);
    rd(3'd6, d); check("R8 rise on both-enabled, none on fall-only", d, 32'h0010_0000);
    wr(3'd6, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = '0;
    repeat (4) @(negedge clk);
    rd(3'd6, d); check("R7 falling events", d, 32'h0010_0002);
    check("R11 irq pin 1", {21'h0, irq_pin}, 32'h2);
    wr(3'd6, 32'h0000_0002);
    rd(3'd6, d); check("R9 zeros leave other bits", d, 32'h0010_0000);
    check("R11 shared irq holds", {31'h0, irq_shared}, 32'h1);

    // R10: rising edge on pin 20 meets a clear of bit 20 in the same cycle
    @(negedge clk); pin_in = 28'h010_0000;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h0010_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    #1 check("R10 edge beats clear", bus_rdata, 32'h0010_0000);
    wr(3'd6, 32'h0010_0000);
    rd(3'd6, d); check("R9 later clear works", d, 32'h0);

    finish_run();
  end
endmodule